// File: doc/BRIEF.md
# Instruction Effective Address Generator

This combinational unit sits between instruction decode and the memory or branch logic of a small 16-bit processor core. From the instruction word, the address of the following instruction and the contents of a base register, it forms the effective address that the current instruction needs. Depending on the opcode in bits 15:12, that address is a branch or call target, a load or store address, or a computed pointer.

Each opcode picks two things: the width of the signed offset taken from the low bits of the instruction, and what the offset is added to. The offset is added either to the next-instruction address or to the base register. For a register jump the base register value passes straight through. For the address-forming opcode, the sum itself is the result that will be written back, and no memory access follows. The unit also always produces the sign-extended 5-bit immediate used by the arithmetic and logic instructions. It flags opcodes that do not form an address.

The register file read, memory access and writeback all happen outside this unit. The caller selects the base register from the instruction's base field (bits 8:6) and supplies its value.

Top module: `ea_gen`

## Requirements
- R1: For opcodes 0x0 (conditional branch), 0x2 (PC-relative load), 0x3 (PC-relative store), 0xA (indirect load), 0xB (indirect store) and 0xE (address form), eff_addr equals pc_next plus instr[8:0] sign-extended.
- R2: For opcode 0x4 with instr[11]=1 (relative call), eff_addr equals pc_next plus instr[10:0] sign-extended.
- R3: For opcode 0xC (register jump), and for opcode 0x4 with instr[11]=0 (register call), eff_addr equals base_val unchanged.
- R4: For opcodes 0x6 (base load) and 0x7 (base store), eff_addr equals base_val plus instr[5:0] sign-extended.
- R5: For every instruction, imm_val equals instr[4:0] sign-extended to the full width.
- R6: For opcodes 0x1, 0x5, 0x8, 0x9, 0xD and 0xF, bad_op is 1 and eff_addr is 0.
- R7: All sums wrap modulo 2^ADDR_W, in both directions.
- R8: For every opcode covered by R1 to R4, bad_op is 0.
- R9: The offset is added to pc_next exactly as supplied, with no correction back to the address of the current instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Current instruction word |
| pc_next | input | ADDR_W | Address of the next instruction |
| base_val | input | ADDR_W | Contents of the selected base register |
| eff_addr | output | ADDR_W | Computed effective address |
| imm_val | output | ADDR_W | Sign-extended 5-bit immediate |
| bad_op | output | 1 | Opcode forms no address |

## Verification
The hardest cases to reach are the wrap-around boundaries. These are a negative offset near address zero and a positive offset near the top of the space, and the sum must wrap there. The opcode-0x4 call shares its offset bits with the base-register field, so the link bit has to be exercised on its own. The directed tasks set pc_next and base_val right at those edges and pick offsets at their extreme values. For the call opcode they keep every other bit fixed and toggle only instr[11], so the bench can see the switch between a relative target and a register target.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

   localparam int INSTR_W = 16;
   localparam int OPC_W   = 4;
   localparam int LINK_B  = 11;

   typedef enum logic [OPC_W-1:0] {
      OP_BRANCH   = 4'h0,
      OP_ADDI     = 4'h1,
      OP_LOADPC   = 4'h2,
      OP_STOREPC  = 4'h3,
      OP_CALL     = 4'h4,
      OP_ANDI     = 4'h5,
      OP_LOADB    = 4'h6,
      OP_STOREB   = 4'h7,
      OP_IRET     = 4'h8,
      OP_INV      = 4'h9,
      OP_LOADIND  = 4'hA,
      OP_STOREIND = 4'hB,
      OP_JUMPR    = 4'hC,
      OP_RESV     = 4'hD,
      OP_ADDRPC   = 4'hE,
      OP_SVC      = 4'hF
   } opcode_e;

   typedef enum logic [1:0] {
      BASE_NONE = 2'd0,
      BASE_PC   = 2'd1,
      BASE_REG  = 2'd2
   } base_sel_e;

   typedef enum logic [1:0] {
      OFF_ZERO  = 2'd0,
      OFF_SHORT = 2'd1,
      OFF_MID   = 2'd2,
      OFF_LONG  = 2'd3
   } off_sel_e;

endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   if (IN_W < 1) begin : g_bad_in
      $error("ea_sext: IN_W must be at least 1");
   end
   if (IN_W > OUT_W) begin : g_bad_out
      $error("ea_sext: IN_W must not exceed OUT_W");
   end

   if (PAD_W == 0) begin : g_same
      assign dout = din;
   end else begin : g_pad
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
   end
endmodule

// File: rtl/ea_decode.sv
module ea_decode
   import ea_gen_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic             link,
   output base_sel_e        base_sel,
   output off_sel_e         off_sel,
   output logic             bad_op
);
   always_comb begin
      base_sel = BASE_NONE;
      off_sel  = OFF_ZERO;
      bad_op   = 1'b0;
      case (opcode_e'(opcode))
         OP_BRANCH, OP_LOADPC, OP_STOREPC,
         OP_LOADIND, OP_STOREIND, OP_ADDRPC: begin
            base_sel = BASE_PC;
            off_sel  = OFF_MID;
         end
         OP_CALL: begin
            if (link) begin
               base_sel = BASE_PC;
               off_sel  = OFF_LONG;
            end else begin
               base_sel = BASE_REG;
               off_sel  = OFF_ZERO;
            end
         end
         OP_LOADB, OP_STOREB: begin
            base_sel = BASE_REG;
            off_sel  = OFF_SHORT;
         end
         OP_JUMPR: begin
            base_sel = BASE_REG;
            off_sel  = OFF_ZERO;
         end
         default: begin
            bad_op = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/ea_offset_sel.sv
module ea_offset_sel
   import ea_gen_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SHORT_W = 6,
   parameter int MID_W   = 9,
   parameter int LONG_W  = 11
) (
   input  logic [LONG_W-1:0] field,
   input  off_sel_e          off_sel,
   output logic [ADDR_W-1:0] offset
);
   localparam int NUM_W = 3;
   localparam int FLD_W [NUM_W] = '{SHORT_W, MID_W, LONG_W};

   if (!(SHORT_W < MID_W && MID_W < LONG_W)) begin : g_bad_order
      $error("ea_offset_sel: field widths must increase strictly");
   end

   logic [ADDR_W-1:0] ext [NUM_W];

   for (genvar gi = 0; gi < NUM_W; gi++) begin : g_ext
      ea_sext #(.IN_W(FLD_W[gi]), .OUT_W(ADDR_W)) u_sx (
         .din  (field[FLD_W[gi]-1:0]),
         .dout (ext[gi])
      );
   end

   always_comb begin
      case (off_sel)
         OFF_SHORT: offset = ext[0];
         OFF_MID:   offset = ext[1];
         OFF_LONG:  offset = ext[2];
         default:   offset = '0;
      endcase
   end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_gen_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IMM_W  = 5
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  pc_next,
   input  logic [ADDR_W-1:0]  base_val,
   output logic [ADDR_W-1:0]  eff_addr,
   output logic [ADDR_W-1:0]  imm_val,
   output logic               bad_op
);
   localparam int SHORT_W = 6;
   localparam int MID_W   = 9;
   localparam int LONG_W  = LINK_B;
   localparam int OPC_LSB = INSTR_W - OPC_W;

   if (ADDR_W < LONG_W + 1) begin : g_bad_addr
      $error("ea_gen: ADDR_W too narrow for the widest offset");
   end
   if (IMM_W < 1 || IMM_W > SHORT_W) begin : g_bad_imm
      $error("ea_gen: IMM_W out of range");
   end

   base_sel_e         base_sel;
   off_sel_e          off_sel;
   logic              dec_bad;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] base_pick;
   logic [ADDR_W-1:0] sum;

   ea_decode u_dec (
      .opcode   (instr[INSTR_W-1:OPC_LSB]),
      .link     (instr[LINK_B]),
      .base_sel (base_sel),
      .off_sel  (off_sel),
      .bad_op   (dec_bad)
   );

   ea_offset_sel #(
      .ADDR_W (ADDR_W), .SHORT_W(SHORT_W), .MID_W(MID_W), .LONG_W(LONG_W)
   ) u_off (
      .field   (instr[LONG_W-1:0]),
      .off_sel (off_sel),
      .offset  (offset)
   );

   ea_sext #(.IN_W(IMM_W), .OUT_W(ADDR_W)) u_imm (
      .din  (instr[IMM_W-1:0]),
      .dout (imm_val)
   );

   always_comb begin
      case (base_sel)
         BASE_PC:  base_pick = pc_next;
         BASE_REG: base_pick = base_val;
         default:  base_pick = '0;
      endcase
   end

   assign sum      = base_pick + offset;
   assign eff_addr = dec_bad ? '0 : sum;
   assign bad_op   = dec_bad;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
   import ea_gen_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic [INSTR_W-1:0] instr,
   input logic [ADDR_W-1:0]  pc_next,
   input logic [ADDR_W-1:0]  base_val,
   input logic [ADDR_W-1:0]  eff_addr,
   input logic [ADDR_W-1:0]  imm_val,
   input logic               bad_op
);
   opcode_e           op;
   logic [ADDR_W-1:0] d_pc;
   logic [ADDR_W-1:0] d_base;
   logic              known;

   always_comb begin
      op     = opcode_e'(instr[15:12]);
      d_pc   = eff_addr - pc_next;
      d_base = eff_addr - base_val;
      known  = !$isunknown({instr, pc_next, base_val, eff_addr, imm_val, bad_op});
      if (known) begin
         // R1
         if (op inside {OP_BRANCH, OP_LOADPC, OP_STOREPC, OP_LOADIND, OP_STOREIND, OP_ADDRPC})
            pc9_window_chk: assert (d_pc[8:0] == instr[8:0] &&
                                    d_pc[ADDR_W-1:8] == {(ADDR_W-8){instr[8]}});
         // R2
         if (op == OP_CALL && instr[11])
            pc11_window_chk: assert (d_pc[10:0] == instr[10:0] &&
                                     d_pc[ADDR_W-1:10] == {(ADDR_W-10){instr[10]}});
         // R3
         if (op == OP_JUMPR || (op == OP_CALL && !instr[11]))
            reg_target_chk: assert (eff_addr == base_val);
         // R4
         if (op inside {OP_LOADB, OP_STOREB})
            base6_window_chk: assert (d_base[5:0] == instr[5:0] &&
                                      d_base[ADDR_W-1:5] == {(ADDR_W-5){instr[5]}});
         // R5
         imm_ext_chk: assert (imm_val[4:0] == instr[4:0] &&
                              imm_val[ADDR_W-1:4] == {(ADDR_W-4){instr[4]}});
         // R6
         if (bad_op)
            bad_zero_chk: assert (eff_addr == '0);
         // R6
         if (op inside {OP_ADDI, OP_ANDI, OP_IRET, OP_INV, OP_RESV, OP_SVC})
            bad_flag_chk: assert (bad_op);
         // R8
         if (!(op inside {OP_ADDI, OP_ANDI, OP_IRET, OP_INV, OP_RESV, OP_SVC}))
            good_flag_chk: assert (!bad_op);
      end
   end
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .instr    (instr),
   .pc_next  (pc_next),
   .base_val (base_val),
   .eff_addr (eff_addr),
   .imm_val  (imm_val),
   .bad_op   (bad_op)
);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] pc_next = '0;
   logic [15:0] base_val = '0;
   logic [15:0] eff_addr;
   logic [15:0] imm_val;
   logic        bad_op;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ea_gen u0 (
      .instr(instr), .pc_next(pc_next), .base_val(base_val),
      .eff_addr(eff_addr), .imm_val(imm_val), .bad_op(bad_op)
   );

   function automatic logic [15:0] sx(input logic [15:0] v, input int n);
      logic [15:0] m;
      m = (16'd1 << n) - 16'd1;
      sx = v & m;
      if (v[n-1]) sx = sx | ~m;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s instr=%h actual=%h expected=%h", tag, instr, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] i, input logic [15:0] pc, input logic [15:0] b);
      @(negedge clk);
      instr = i; pc_next = pc; base_val = b;
      #1;
   endtask

   task automatic t_reset();
      #1;
      check("R1 idle-zero ea", eff_addr, 16'h0000);
      check("R8 idle-zero flag", {15'd0, bad_op}, 16'h0000);
   endtask

   task automatic t_pc9();
      logic [3:0] ops [6] = '{4'h0, 4'h2, 4'h3, 4'hA, 4'hB, 4'hE};
      logic [8:0] offs [3] = '{9'h0FF, 9'h100, 9'h1F3};
      foreach (ops[k]) begin
         foreach (offs[j]) begin
            apply({ops[k], 3'b101, offs[j]}, 16'h3000, 16'hBEEF);
            check("R1 pc9 ea", eff_addr, 16'h3000 + sx({7'd0, offs[j]}, 9));
            check("R8 pc9 flag", {15'd0, bad_op}, 16'h0000);
         end
      end
      apply({4'h0, 3'b111, 9'h001}, 16'h4001, 16'h0);
      check("R9 next-pc base", eff_addr, 16'h4002);
   endtask

   task automatic t_call();
      apply({4'h4, 1'b1, 11'h3FF}, 16'h2000, 16'h7777);
      check("R2 call max", eff_addr, 16'h23FF);
      apply({4'h4, 1'b1, 11'h400}, 16'h2000, 16'h7777);
      check("R2 call min", eff_addr, 16'h1C00);
      apply({4'h4, 1'b0, 11'h400}, 16'h2000, 16'h7777);
      check("R3 call-reg", eff_addr, 16'h7777);
      check("R8 call-reg flag", {15'd0, bad_op}, 16'h0000);
   endtask

   task automatic t_jump();
      apply({4'hC, 3'b000, 3'b111, 6'h3F}, 16'h1234, 16'hA5A5);
      check("R3 jump ignores offset", eff_addr, 16'hA5A5);
      apply({4'hC, 12'hFFF}, 16'hFFFF, 16'h0000);
      check("R3 jump zero", eff_addr, 16'h0000);
   endtask

   task automatic t_base6();
      apply({4'h6, 3'd1, 3'd2, 6'h1F}, 16'h9999, 16'h5000);
      check("R4 load-base +31", eff_addr, 16'h501F);
      apply({4'h7, 3'd1, 3'd2, 6'h20}, 16'h9999, 16'h5000);
      check("R4 store-base -32", eff_addr, 16'h4FE0);
   endtask

   task automatic t_imm();
      for (int v = 0; v < 32; v++) begin
         apply({4'h1, 7'h55, v[4:0]}, 16'h0, 16'h0);
         check("R5 imm", imm_val, sx(16'(v), 5));
      end
      apply({4'hE, 7'h00, 5'h10}, 16'h0, 16'h0);
      check("R5 imm on non-arith", imm_val, 16'hFFF0);
   endtask

   task automatic t_bad();
      logic [3:0] ops [6] = '{4'h1, 4'h5, 4'h8, 4'h9, 4'hD, 4'hF};
      foreach (ops[k]) begin
         apply({ops[k], 12'hFFF}, 16'h8000, 16'h4321);
         check("R6 bad ea", eff_addr, 16'h0000);
         check("R6 bad flag", {15'd0, bad_op}, 16'h0001);
      end
   endtask

   task automatic t_wrap();
      apply({4'h2, 3'd0, 9'h1FF}, 16'h0000, 16'h0);
      check("R7 wrap under pc", eff_addr, 16'hFFFF);
      apply({4'h4, 1'b1, 11'h3FF}, 16'hFF00, 16'h0);
      check("R7 wrap over pc", eff_addr, 16'h02FF);
      apply({4'h6, 6'd0, 6'h01}, 16'h0, 16'hFFFF);
      check("R7 wrap over base", eff_addr, 16'h0000);
   endtask

   initial begin
      t_reset();
      t_pc9();
      t_call();
      t_jump();
      t_base6();
      t_imm();
      t_bad();
      t_wrap();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule